// File: doc/BRIEF.md
# Strobe-Addressed Bit Array Interface

This block is a behavioural model of a one-bit-wide dynamic-style memory whose cell address reaches it in two halves over a single shared bus. A row half is presented first and qualified by an active-low row strobe. The column half follows on the same pins and is qualified by an active-low column strobe. Once both halves are in, the block reads or writes the single cell they select. It has one serial data input, one serial data output and a read/write select.

All strobe and data pins are sampled on the rising edge of one system clock. A register update or a cell write takes effect at the first edge where the relevant strobe is seen low. The bus width `ADDR_W` sets both the row count and the column count at 2^`ADDR_W`. `ADDR_W` = 8 gives the full 256 by 256 organisation, which is 65,536 cells. The default is 5, so that the default elaboration stays small.

A column-strobe fall that arrives without a row address first is treated as a protocol violation. It is reported by a one-cycle error pulse and causes no cell access.

Top module: `strobe_bit_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `dout` and `proto_err` are 0. Reset clears every cell to 0.
- R2: At each clock edge where `row_stb_n` is 0 and `col_stb_n` is 1, the row register takes the value on `addr`. When the bus changes during that phase, the value at the last such edge is the one kept.
- R3: At each clock edge where both strobes are 0, the cell addressed is the one at row = row register and column = `addr` at that edge. The row register does not change while `col_stb_n` is 0.
- R4: At an edge where both strobes are 0 and `rd_wr` is 0 (0 = write), the value of `din` is stored into the addressed cell. A later read of that cell returns it.
- R5: At an edge where both strobes are 0 and `rd_wr` is 1 (1 = read), `dout` shows the addressed cell's content from that edge until the next edge.
- R6: After any edge where the read condition of R5 does not hold, `dout` is 0.
- R7: At an edge where `col_stb_n` is 0 and `row_stb_n` is 1, and `col_stb_n` was 1 at the previous edge, `proto_err` is 1 for the following cycle only. Such an edge writes no cell.
- R8: `proto_err` is 0 after every edge other than the one described in R7. This includes edges where the column strobe stays low while the row strobe is high.
- R9: Several column accesses may follow one row phase without the row strobe being released. Each uses the same row and its own column value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Shared bus carrying the row half, then the column half |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not reading |
| proto_err | output | 1 | One-cycle pulse on a column-strobe fall without a row phase |

## Verification
The hardest case to reach is a column-strobe fall while the row strobe is high. It has to arrive with the write select low and `din` at 1, so that a wrongly performed access would leave a visible 1 in a cell. The stimulus holds a previously used row in the row register, clears the target cell first, and then forces exactly that strobe order. After that it holds the column strobe low for several more cycles to show that only one pulse appears. A later normal read of the cell then shows whether the violating edge touched it. Long sequences of random accesses, including several columns per row phase, are compared each cycle against a behavioural reference array.

// File: rtl/strobe_bit_array_pkg.sv
package strobe_bit_array_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2,
        PH_BAD  = 2'd3
    } strobe_phase_e;

    typedef struct packed {
        logic row_load;
        logic col_load;
        logic do_read;
        logic do_write;
        logic bad_fall;
    } strobe_ctl_t;

    function automatic strobe_phase_e phase_of(input logic row_n, input logic col_n);
        strobe_phase_e ph;
        unique case ({row_n, col_n})
            2'b11:   ph = PH_IDLE;
            2'b01:   ph = PH_ROW;
            2'b00:   ph = PH_COL;
            default: ph = PH_BAD;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
    import strobe_bit_array_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        row_stb_n,
    input  logic        col_stb_n,
    input  logic        rd_wr,
    output strobe_ctl_t ctl
);

    logic          col_prev_q;
    strobe_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) col_prev_q <= 1'b1;
        else     col_prev_q <= col_stb_n;
    end

    always_comb begin
        phase        = phase_of(row_stb_n, col_stb_n);
        ctl          = '0;
        ctl.row_load = (phase == PH_ROW);
        ctl.col_load = !col_stb_n;
        ctl.do_read  = (phase == PH_COL) && rd_wr;
        ctl.do_write = (phase == PH_COL) && !rd_wr;
        ctl.bad_fall = (phase == PH_BAD) && col_prev_q;
    end

endmodule

// File: rtl/strobe_addr_regs.sv
module strobe_addr_regs #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_load,
    input  logic              col_load,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] row_sel,
    output logic [ADDR_W-1:0] col_sel
);

    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (row_load) row_q <= addr;
            if (col_load) col_q <= addr;
        end
    end

    assign row_sel = row_q;
    assign col_sel = col_load ? addr : col_q;

endmodule

// File: rtl/strobe_cell_array.sv
module strobe_cell_array #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] row_sel,
    input  logic [ADDR_W-1:0] col_sel,
    output logic              rd_bit
);

    localparam int NROW = 1 << ADDR_W;
    localparam int NCOL = 1 << ADDR_W;

    logic [NCOL-1:0] row_word [NROW];

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic [NCOL-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (rst)
                bits_q <= '0;
            else if (wr_en && (row_sel == ADDR_W'(r)))
                bits_q[col_sel] <= wr_bit;
        end
        assign row_word[r] = bits_q;
    end

    assign rd_bit = row_word[row_sel][col_sel];

endmodule

// File: rtl/strobe_bit_array.sv
module strobe_bit_array
    import strobe_bit_array_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              proto_err
);

    strobe_ctl_t       ctl;
    logic [ADDR_W-1:0] row_sel;
    logic [ADDR_W-1:0] col_sel;
    logic              rd_bit;
    logic              dout_q;
    logic              err_q;

    strobe_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .rd_wr     (rd_wr),
        .ctl       (ctl)
    );

    strobe_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .row_load (ctl.row_load),
        .col_load (ctl.col_load),
        .addr     (addr),
        .row_sel  (row_sel),
        .col_sel  (col_sel)
    );

    strobe_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl.do_write),
        .wr_bit  (din),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .rd_bit  (rd_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            dout_q <= ctl.do_read ? rd_bit : 1'b0;
            err_q  <= ctl.bad_fall;
        end
    end

    assign dout      = dout_q;
    assign proto_err = err_q;

endmodule

// File: rtl/strobe_bit_array_chk.sv
module strobe_bit_array_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              row_stb_n,
    input logic              col_stb_n,
    input logic              rd_wr,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic              dout,
    input logic              proto_err
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!dout && !proto_err));

    p_dout_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !(!row_stb_n && !col_stb_n && rd_wr) |=> !dout);

    p_err_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (row_stb_n && $fell(col_stb_n)) |=> proto_err);

    p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> !proto_err);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        !(row_stb_n && !col_stb_n) |=> !proto_err);

    p_dout_known_r5: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(dout));

endmodule

bind strobe_bit_array strobe_bit_array_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .rd_wr     (rd_wr),
    .addr      (addr),
    .din       (din),
    .dout      (dout),
    .proto_err (proto_err)
);

// File: tb/tb_strobe_bit_array.sv
module tb_strobe_bit_array;

    localparam int AW    = 5;
    localparam int NCOL  = 1 << AW;
    localparam int NCELL = NCOL * NCOL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          row_stb_n = 1'b1;
    logic          col_stb_n = 1'b1;
    logic          rd_wr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          din = 1'b0;
    logic          dout;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit ref_mem [NCELL];
    int ref_row;
    bit ref_prev_col;
    bit exp_dout;
    bit exp_err;

    always #2 clk = ~clk;

    strobe_bit_array #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .rd_wr     (rd_wr),
        .addr      (addr),
        .din       (din),
        .dout      (dout),
        .proto_err (proto_err)
    );

    // behavioural reference, evaluated on each rising edge from the inputs held since the falling edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCELL; i++) ref_mem[i] = 1'b0;
            ref_row      = 0;
            ref_prev_col = 1'b1;
            exp_dout     = 1'b0;
            exp_err      = 1'b0;
        end else begin
            exp_err  = (!col_stb_n && row_stb_n && ref_prev_col);
            exp_dout = 1'b0;
            if (!row_stb_n && col_stb_n) ref_row = int'(addr);
            if (!row_stb_n && !col_stb_n) begin
                if (rd_wr) exp_dout = ref_mem[ref_row * NCOL + int'(addr)];
                else       ref_mem[ref_row * NCOL + int'(addr)] = din;
            end
            ref_prev_col = col_stb_n;
        end
    end

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // advance one clock and compare both outputs to the reference
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_bit(cur_req, "dout", dout, exp_dout);
        check_bit(cur_req, "proto_err", proto_err, exp_err);
    endtask

    task automatic drive(input logic rn, input logic cn, input logic rw, input int a, input logic d);
        row_stb_n = rn; col_stb_n = cn; rd_wr = rw; addr = AW'(a); din = d;
        tick();
    endtask

    task automatic access(input int r, input int c, input logic rw, input logic d);
        drive(1'b0, 1'b1, 1'b1, r, 1'b0);
        drive(1'b0, 1'b0, rw, c, d);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
    endtask

    task automatic read_expect(input string req, input int r, input int c, input logic exp);
        drive(1'b0, 1'b1, 1'b1, r, 1'b0);
        drive(1'b0, 1'b0, 1'b1, c, 1'b0);
        check_bit(req, "readback", dout, exp);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1", "dout in reset", dout, 1'b0);
        check_bit("R1", "err in reset", proto_err, 1'b0);
        rst = 1'b0;
        cur_req = "R1";
        tick();
        read_expect("R1", 7, 9, 1'b0);

        // R4/R5: write then read several patterns
        cur_req = "R4";
        access(3, 4, 1'b0, 1'b1);
        access(0, 0, 1'b0, 1'b1);
        access(NCOL - 1, NCOL - 1, 1'b0, 1'b1);
        access(3, 5, 1'b0, 1'b0);
        cur_req = "R5";
        read_expect("R5", 3, 4, 1'b1);
        read_expect("R5", 0, 0, 1'b1);
        read_expect("R5", NCOL - 1, NCOL - 1, 1'b1);
        read_expect("R5", 3, 5, 1'b0);
        read_expect("R3", 4, 3, 1'b0);

        // R2: last row value during row phase wins
        cur_req = "R2";
        drive(1'b0, 1'b1, 1'b1, 10, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 11, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 12, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 6, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
        read_expect("R2", 12, 6, 1'b1);
        read_expect("R2", 10, 6, 1'b0);

        // R9/R3: several columns per row phase, row held while column strobe low
        cur_req = "R9";
        drive(1'b0, 1'b1, 1'b1, 20, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 2, 1'b1);
        drive(1'b0, 1'b1, 1'b1, 20, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 3, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 2, 1'b0);
        check_bit("R9", "same-row read", dout, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
        read_expect("R3", 20, 3, 1'b1);
        read_expect("R3", 1, 3, 1'b0);

        // R6: write phase and row-only phase leave dout low
        cur_req = "R6";
        drive(1'b0, 1'b1, 1'b1, 3, 1'b0);
        check_bit("R6", "dout in row phase", dout, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 4, 1'b1);
        check_bit("R6", "dout in write", dout, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);

        // R7/R8: column fall with row high; no write, one pulse only
        cur_req = "R7";
        access(5, 8, 1'b0, 1'b0);
        drive(1'b0, 1'b1, 1'b1, 5, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 5, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 8, 1'b1);
        check_bit("R7", "err pulse", proto_err, 1'b1);
        cur_req = "R8";
        drive(1'b1, 1'b0, 1'b0, 8, 1'b1);
        check_bit("R8", "no repeat pulse", proto_err, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 8, 1'b1);
        drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
        read_expect("R7", 5, 8, 1'b0);

        // random traffic against the reference
        cur_req = "R4";
        for (int n = 0; n < 1500; n++) begin
            int r;
            int k;
            r = int'($urandom_range(NCOL - 1));
            k = int'($urandom_range(3));
            drive(1'b0, 1'b1, 1'b1, r, 1'b0);
            for (int j = 0; j <= k; j++)
                drive(1'b0, 1'b0, 1'($urandom_range(1)), int'($urandom_range(NCOL - 1)), 1'($urandom_range(1)));
            if ($urandom_range(7) == 0)
                drive(1'b1, 1'b0, 1'b1, 0, 1'b0);
            drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
        end

        // full readback sweep
        cur_req = "R5";
        for (int r = 0; r < NCOL; r++) begin
            drive(1'b0, 1'b1, 1'b1, r, 1'b0);
            for (int c = 0; c < NCOL; c++)
                drive(1'b0, 1'b0, 1'b1, c, 1'b0);
            drive(1'b1, 1'b1, 1'b1, 0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule